// File: doc/BRIEF.md
# Direct-Page Word Transfer Bus Sequencer

This block drives the external byte-wide bus of a small processor core while it executes 16-bit instructions whose operand sits in the zero page. It fetches opcodes and the one-byte operand address itself. It generates the exact address, read/write direction and write byte for every clock. It also holds the program counter and a file of four 16-bit registers, one of which is the stack pointer. An external decoder looks at the byte being read during each opcode-fetch cycle and tells the sequencer which instruction class it is and which register it names.

Six classes are sequenced. A plain or unclassified opcode is a single fetch. A prefix byte adds one extra fetch cycle before the real opcode. A word load reads two bytes, high byte first, into the named register. A word store writes the named register high byte first. An arithmetic/compare reads two bytes and then spends one dummy read cycle at the all-ones address; its result logic lives elsewhere. A subroutine call reads the first opcode of the target before pushing the return address onto the stack.

Top module: `dp_bus_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the bus shows an opcode fetch (op_fetch_o=1, rw_o=1) at rst_pc_i. All four registers read as zero after reset.
- R2: A word load (op_kind 2) spans four cycles: fetch at PC, read at PC+1, read at EA, read at EA+1. The next fetch is at PC+2.
- R3: A word load writes {byte read at EA, byte read at EA+1} into the register named by op_reg (0=D, 1=X, 2=Y, 3=stack pointer).
- R4: A word store (op_kind 3) spans four cycles: fetch at PC, read at PC+1, write of the register's bits 15:8 at EA, write of bits 7:0 at EA+1. Writes always come in adjacent pairs.
- R5: A prefix byte (op_kind 1) costs exactly one cycle and is followed by another opcode fetch at the next address. Every opcode fetch is a read.
- R6: An arithmetic/compare (op_kind 4) spans five cycles. The fifth is a read of address 0xFFFF, and no register changes.
- R7: A call (op_kind 5) spans five cycles: fetch at PC, read at PC+1, read at the target T, write of (PC+2)[7:0] at SP, write of (PC+2)[15:8] at SP-1.
- R8: After a call, the stack pointer equals its old value minus 2, and the next fetch is at T+1.
- R9: EA is {0x00, operand byte}. EA+1 is a full 16-bit increment, so operand 0xFF gives a second access at 0x0100.
- R10: In every read cycle, wdata_o holds the value it had in the previous cycle.
- R11: An opcode with an unused class (op_kind 0, 6 or 7) costs one cycle, and the next fetch is at PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pc_i | input | 16 | Program counter value loaded on reset |
| rd_data_i | input | 8 | Read data for the current bus cycle |
| op_kind_i | input | 3 | Decoded class of the byte read in an opcode-fetch cycle |
| op_reg_i | input | 2 | Register named by that opcode |
| addr_o | output | 16 | Bus address of the current cycle |
| rw_o | output | 1 | 1 = read, 0 = write |
| wdata_o | output | 8 | Write data |
| op_fetch_o | output | 1 | Current cycle is an opcode fetch |

## Verification
On every cycle, the assertions check properties that hold in any state. Opcode fetches are reads. Write cycles come in pairs, and a pair never stretches to three. The write byte is frozen during reads. The dummy cycle sits at 0xFFFF. Operand-page accesses have a zero high byte. The second access of an operand, and the stack push, step the address by one in the right direction. Only the bench scenarios can show the rest: the data value carried on each write, the full cycle count of each class, the return address pushed, and the updated stack pointer and resume address after a call. Register contents are seen only by storing them back out. The bench therefore sweeps loads and stores over all four registers at page edges, then checks that arithmetic leaves them unchanged.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    S_FETCH,
    S_ADRB,
    S_RDH,
    S_RDL,
    S_WRH,
    S_WRL,
    S_DUMMY,
    S_CALLOP,
    S_PUSHL,
    S_PUSHH
  } state_t;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_PRE   = 3'd1,
    K_LOAD  = 3'd2,
    K_STORE = 3'd3,
    K_ARITH = 3'd4,
    K_CALL  = 3'd5
  } kind_t;

endpackage

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int RW   = 16,
  parameter int NREG = 4,
  parameter int SPI  = 3,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [RW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [RW-1:0] rdata_o,
  input  logic          sp_we_i,
  input  logic [RW-1:0] sp_wdata_i,
  output logic [RW-1:0] sp_o
);

  logic [RW-1:0] ent [NREG];

  always_ff @(posedge clk) begin
    for (int g = 0; g < NREG; g++) begin
      if (rst) begin
        ent[g] <= '0;
      end else if (sp_we_i && g == SPI) begin
        ent[g] <= sp_wdata_i;
      end else if (we_i && waddr_i == IW'(g)) begin
        ent[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = ent[raddr_i];
  assign sp_o    = ent[SPI];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RW  = 2 * DW,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rst_pc_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [2:0]    op_kind_i,
  input  logic [IW-1:0] op_reg_i,
  input  logic [RW-1:0] reg_rdata_i,
  input  logic [RW-1:0] sp_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] wdata_o,
  output logic          op_fetch_o,
  output state_t        st_o,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_idx_o,
  output logic [RW-1:0] rf_wdata_o,
  output logic          sp_we_o,
  output logic [RW-1:0] sp_wdata_o
);

  localparam logic [AW-1:0] DUMMY_ADDR = '1;
  localparam int            PGW        = AW - DW;

  state_t        st, st_n;
  kind_t         kind, kind_n;
  logic [IW-1:0] cur, cur_n;
  logic [AW-1:0] pc, pc_n;
  logic [AW-1:0] ea, ea_n;
  logic [DW-1:0] hi, hi_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          rw_q, rw_n;
  logic [DW-1:0] wd_q, wd_n;
  logic          opf_q, opf_n;
  logic [AW-1:0] page_ea;

  assign page_ea = {{PGW{1'b0}}, rd_data_i};

  always_comb begin
    st_n       = S_FETCH;
    kind_n     = kind;
    cur_n      = cur;
    pc_n       = pc;
    ea_n       = ea;
    hi_n       = hi;
    addr_n     = pc;
    rw_n       = 1'b1;
    wd_n       = wd_q;
    opf_n      = 1'b0;
    rf_we_o    = 1'b0;
    rf_wdata_o = {hi, rd_data_i};
    sp_we_o    = 1'b0;
    sp_wdata_o = sp_i - RW'(2);
    unique case (st)
      S_FETCH: begin
        kind_n = kind_t'(op_kind_i);
        cur_n  = op_reg_i;
        pc_n   = pc + 1'b1;
        addr_n = pc + 1'b1;
        if (op_kind_i == K_LOAD || op_kind_i == K_STORE ||
            op_kind_i == K_ARITH || op_kind_i == K_CALL) begin
          st_n = S_ADRB;
        end else begin
          st_n  = S_FETCH;
          opf_n = 1'b1;
        end
      end
      S_ADRB: begin
        ea_n   = page_ea;
        pc_n   = pc + 1'b1;
        addr_n = page_ea;
        unique case (kind)
          K_LOAD, K_ARITH: st_n = S_RDH;
          K_STORE: begin
            st_n = S_WRH;
            rw_n = 1'b0;
            wd_n = reg_rdata_i[RW-1:DW];
          end
          K_CALL: st_n = S_CALLOP;
          default: begin
            st_n   = S_FETCH;
            addr_n = pc + 1'b1;
            opf_n  = 1'b1;
          end
        endcase
      end
      S_RDH: begin
        hi_n   = rd_data_i;
        st_n   = S_RDL;
        addr_n = ea + 1'b1;
      end
      S_RDL: begin
        rf_we_o = (kind == K_LOAD);
        if (kind == K_ARITH) begin
          st_n   = S_DUMMY;
          addr_n = DUMMY_ADDR;
        end else begin
          opf_n = 1'b1;
        end
      end
      S_DUMMY: opf_n = 1'b1;
      S_WRH: begin
        st_n   = S_WRL;
        addr_n = ea + 1'b1;
        rw_n   = 1'b0;
        wd_n   = reg_rdata_i[DW-1:0];
      end
      S_WRL: opf_n = 1'b1;
      S_CALLOP: begin
        st_n   = S_PUSHL;
        addr_n = sp_i[AW-1:0];
        rw_n   = 1'b0;
        wd_n   = pc[DW-1:0];
      end
      S_PUSHL: begin
        st_n   = S_PUSHH;
        addr_n = sp_i[AW-1:0] - 1'b1;
        rw_n   = 1'b0;
        wd_n   = pc[AW-1:DW];
      end
      S_PUSHH: begin
        sp_we_o = 1'b1;
        pc_n    = ea + 1'b1;
        addr_n  = ea + 1'b1;
        opf_n   = 1'b1;
      end
      default: opf_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_FETCH;
      kind   <= K_NONE;
      cur    <= '0;
      pc     <= rst_pc_i;
      ea     <= '0;
      hi     <= '0;
      addr_q <= rst_pc_i;
      rw_q   <= 1'b1;
      wd_q   <= '0;
      opf_q  <= 1'b1;
    end else begin
      st     <= st_n;
      kind   <= kind_n;
      cur    <= cur_n;
      pc     <= pc_n;
      ea     <= ea_n;
      hi     <= hi_n;
      addr_q <= addr_n;
      rw_q   <= rw_n;
      wd_q   <= wd_n;
      opf_q  <= opf_n;
    end
  end

  assign addr_o     = addr_q;
  assign rw_o       = rw_q;
  assign wdata_o    = wd_q;
  assign op_fetch_o = opf_q;
  assign st_o       = st;
  assign rf_idx_o   = cur;

endmodule

// File: rtl/dp_bus_seq.sv
module dp_bus_seq
  import seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int NREG = 4,
  parameter int SPI  = 3,
  localparam int RW  = 2 * DW,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rst_pc_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [2:0]    op_kind_i,
  input  logic [IW-1:0] op_reg_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic [DW-1:0] wdata_o,
  output logic          op_fetch_o
);

  state_t        st;
  logic          rf_we;
  logic [IW-1:0] rf_idx;
  logic [RW-1:0] rf_wdata;
  logic [RW-1:0] rf_rdata;
  logic          sp_we;
  logic [RW-1:0] sp_wdata;
  logic [RW-1:0] sp_val;

  seq_regfile #(.RW(RW), .NREG(NREG), .SPI(SPI)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we_i      (rf_we),
    .waddr_i   (rf_idx),
    .wdata_i   (rf_wdata),
    .raddr_i   (rf_idx),
    .rdata_o   (rf_rdata),
    .sp_we_i   (sp_we),
    .sp_wdata_i(sp_wdata),
    .sp_o      (sp_val)
  );

  seq_ctrl #(.AW(AW), .DW(DW), .NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rst_pc_i   (rst_pc_i),
    .rd_data_i  (rd_data_i),
    .op_kind_i  (op_kind_i),
    .op_reg_i   (op_reg_i),
    .reg_rdata_i(rf_rdata),
    .sp_i       (sp_val),
    .addr_o     (addr_o),
    .rw_o       (rw_o),
    .wdata_o    (wdata_o),
    .op_fetch_o (op_fetch_o),
    .st_o       (st),
    .rf_we_o    (rf_we),
    .rf_idx_o   (rf_idx),
    .rf_wdata_o (rf_wdata),
    .sp_we_o    (sp_we),
    .sp_wdata_o (sp_wdata)
  );

endmodule

// File: rtl/dp_bus_seq_chk.sv
module dp_bus_seq_chk
  import seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rst_pc_i,
  input logic [AW-1:0] addr_o,
  input logic          rw_o,
  input logic [DW-1:0] wdata_o,
  input logic          op_fetch_o,
  input state_t        st
);

  // R1: reset leaves an opcode fetch at the reset address
  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (addr_o == $past(rst_pc_i) && rw_o && op_fetch_o));

  // R2: second operand access is one above the first
  a_r2_second_read: assert property (@(posedge clk) disable iff (rst)
    st == S_RDH |=> (st == S_RDL && rw_o && addr_o == AW'($past(addr_o) + 1'b1)));

  // R4: a write is always followed by exactly one more write
  a_r4_write_pair: assert property (@(posedge clk) disable iff (rst)
    $fell(rw_o) |=> !rw_o);

  a_r4_write_end: assert property (@(posedge clk) disable iff (rst)
    (!rw_o && !$past(rw_o)) |=> rw_o);

  // R5: every opcode fetch is a read
  a_r5_fetch_read: assert property (@(posedge clk) disable iff (rst)
    op_fetch_o |-> rw_o);

  // R6: dummy cycle reads the all-ones address
  a_r6_dummy_addr: assert property (@(posedge clk) disable iff (rst)
    st == S_DUMMY |-> (addr_o == {AW{1'b1}} && rw_o));

  // R7: return address high byte goes one below the low byte
  a_r7_push_order: assert property (@(posedge clk) disable iff (rst)
    st == S_PUSHL |=> (st == S_PUSHH && !rw_o && addr_o == AW'($past(addr_o) - 1'b1)));

  // R9: first operand access and call target lie in page zero
  a_r9_page_zero: assert property (@(posedge clk) disable iff (rst)
    (st == S_RDH || st == S_WRH || st == S_CALLOP) |-> addr_o[AW-1:DW] == '0);

  // R10: write data frozen during reads
  a_r10_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    rw_o |-> $stable(wdata_o));

endmodule

bind dp_bus_seq dp_bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_pc_i  (rst_pc_i),
  .addr_o    (addr_o),
  .rw_o      (rw_o),
  .wdata_o   (wdata_o),
  .op_fetch_o(op_fetch_o),
  .st        (st)
);

// File: tb/sim_dp_bus_seq.sv
module sim_dp_bus_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] rst_pc;
  logic [7:0]  rdata;
  logic [2:0]  kind;
  logic [1:0]  rsel;
  logic [15:0] addr;
  logic        rw;
  logic [7:0]  wdata;
  logic        opf;

  always #5 clk = ~clk;

  dp_bus_seq u0 (
    .clk       (clk),
    .rst       (rst),
    .rst_pc_i  (rst_pc),
    .rd_data_i (rdata),
    .op_kind_i (kind),
    .op_reg_i  (rsel),
    .addr_o    (addr),
    .rw_o      (rw),
    .wdata_o   (wdata),
    .op_fetch_o(opf)
  );

  logic [7:0] mem [0:4095];
  assign rdata = (addr == 16'hFFFF) ? 8'hEE : mem[addr[11:0]];
  // bench decoder: bits 6:4 = class, bits 1:0 = register
  assign kind  = rdata[6:4];
  assign rsel  = rdata[1:0];

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] pc_m;
  logic [15:0] regs_m [4];
  logic [7:0]  last_wd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[a[11:0]] = d;
  endtask

  task automatic step(input logic [15:0] ea, input bit erw, input logic [7:0] ewd,
                      input bit eopf, input string req);
    chk(addr == ea, req, 32'(addr), 32'(ea));
    chk(rw == erw, req, 32'(rw), 32'(erw));
    chk(opf == eopf, req, 32'(opf), 32'(eopf));
    if (erw) begin
      chk(wdata == last_wd, "R10", 32'(wdata), 32'(last_wd));
    end else begin
      chk(wdata == ewd, req, 32'(wdata), 32'(ewd));
      last_wd = ewd;
      mem[addr[11:0]] = wdata;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] pcv);
    rst    = 1'b1;
    rst_pc = pcv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst  = 1'b0;
    pc_m = pcv;
    for (int i = 0; i < 4; i++) regs_m[i] = '0;
    last_wd = '0;
    chk(addr == pcv && rw && opf, "R1", {addr, 7'b0, rw, 7'b0, opf}, {pcv, 16'h0101});
  endtask

  task automatic i_load(input logic [1:0] r, input logic [7:0] e, input logic [15:0] v);
    logic [15:0] p = pc_m;
    logic [15:0] a = {8'h00, e};
    if (r == 2'd2) begin
      put(p, 8'h18);
      step(p, 1'b1, 8'h00, 1'b1, "R5");
      p = p + 16'd1;
    end
    put(p, 8'h20 | {6'd0, r});
    put(p + 16'd1, e);
    put(a, v[15:8]);
    put(a + 16'd1, v[7:0]);
    step(p, 1'b1, 8'h00, 1'b1, "R2");
    step(p + 16'd1, 1'b1, 8'h00, 1'b0, "R2");
    step(a, 1'b1, 8'h00, 1'b0, "R9");
    step(a + 16'd1, 1'b1, 8'h00, 1'b0, "R9");
    pc_m = p + 16'd2;
    regs_m[r] = v;
  endtask

  task automatic i_store(input logic [1:0] r, input logic [7:0] e, input string req);
    logic [15:0] p = pc_m;
    logic [15:0] a = {8'h00, e};
    if (r == 2'd2) begin
      put(p, 8'h18);
      step(p, 1'b1, 8'h00, 1'b1, "R5");
      p = p + 16'd1;
    end
    put(p, 8'h30 | {6'd0, r});
    put(p + 16'd1, e);
    step(p, 1'b1, 8'h00, 1'b1, "R4");
    step(p + 16'd1, 1'b1, 8'h00, 1'b0, "R4");
    step(a, 1'b0, regs_m[r][15:8], 1'b0, req);
    step(a + 16'd1, 1'b0, regs_m[r][7:0], 1'b0, req);
    pc_m = p + 16'd2;
  endtask

  task automatic i_arith(input bit pre, input logic [7:0] e);
    logic [15:0] p = pc_m;
    logic [15:0] a = {8'h00, e};
    if (pre) begin
      put(p, 8'h18);
      step(p, 1'b1, 8'h00, 1'b1, "R5");
      p = p + 16'd1;
    end
    put(p, 8'h41);
    put(p + 16'd1, e);
    put(a, e ^ 8'h5A);
    put(a + 16'd1, e ^ 8'hA5);
    step(p, 1'b1, 8'h00, 1'b1, "R6");
    step(p + 16'd1, 1'b1, 8'h00, 1'b0, "R6");
    step(a, 1'b1, 8'h00, 1'b0, "R6");
    step(a + 16'd1, 1'b1, 8'h00, 1'b0, "R6");
    step(16'hFFFF, 1'b1, 8'h00, 1'b0, "R6");
    pc_m = p + 16'd2;
  endtask

  task automatic i_other(input logic [7:0] op);
    put(pc_m, op);
    step(pc_m, 1'b1, 8'h00, 1'b1, "R11");
    pc_m = pc_m + 16'd1;
  endtask

  task automatic i_call(input logic [7:0] t);
    logic [15:0] p   = pc_m;
    logic [15:0] ret = pc_m + 16'd2;
    logic [15:0] sp  = regs_m[3];
    put(p, 8'h50);
    put(p + 16'd1, t);
    put({8'h00, t}, 8'h00);
    step(p, 1'b1, 8'h00, 1'b1, "R7");
    step(p + 16'd1, 1'b1, 8'h00, 1'b0, "R7");
    step({8'h00, t}, 1'b1, 8'h00, 1'b0, "R7");
    step(sp, 1'b0, ret[7:0], 1'b0, "R7");
    step(sp - 16'd1, 1'b0, ret[15:8], 1'b0, "R7");
    regs_m[3] = sp - 16'd2;
    pc_m = {8'h00, t} + 16'd1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] eas [5];
    eas[0] = 8'h00; eas[1] = 8'h10; eas[2] = 8'h7F; eas[3] = 8'hFE; eas[4] = 8'hFF;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst    = 1'b1;
    rst_pc = 16'h0400;
    last_wd = '0;

    do_reset(16'h0400);
    // R1: registers cleared, seen through stores
    for (int r = 0; r < 4; r++) i_store(2'(r), 8'h20 + 8'(2 * r), "R1");

    // R3 / R4 / R9: load then store every register at page corners
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 5; k++) begin
        i_load(2'(r), eas[k], 16'h1234 + 16'(r) * 16'h2111 + 16'(k) * 16'h0F0F);
        i_store(2'(r), eas[k] ^ 8'h80, "R3");
      end
    end

    // R6: arithmetic, plain and prefixed, leaves registers alone
    for (int k = 0; k < 5; k++) i_arith(k[0], eas[k]);
    for (int r = 0; r < 4; r++) i_store(2'(r), 8'h30 + 8'(2 * r), "R6");

    // R11: unused classes, interleaved with a load
    i_other(8'h00);
    i_other(8'h60);
    i_load(2'd1, 8'h05, 16'hBEEF);
    i_other(8'h73);
    i_store(2'd1, 8'h08, "R11");

    // R7 / R8: two nested calls
    i_load(2'd3, 8'h50, 16'h0800);
    i_call(8'h40);
    i_store(2'd3, 8'h60, "R8");
    i_call(8'h90);
    i_store(2'd3, 8'h62, "R8");
    chk(regs_m[3] == 16'h07FC, "R8", 32'(regs_m[3]), 32'h07FC);

    // R1: second reset at a new address clears loaded values
    do_reset(16'h0A00);
    i_store(2'd1, 8'h20, "R1");
    i_store(2'd2, 8'h22, "R1");
    i_store(2'd3, 8'h24, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule